// File: doc/BRIEF.md
# Multi-Event Readout Ring Buffer

This block holds completed digitizer events between the capture side and the readout side. The capture side opens an event with a start strobe, streams its data words, and closes it with an end strobe. A closed event does not become readable at once. It first waits out a programmable fast-clear window. A rising edge on the fast-clear input during that window throws the event away and frees its slot for the next capture. Once the window expires, the event is committed and given a 3-bit event tag that counts committed events modulo 8.

Up to eight committed events are held in slots used in ring order. The reader always works on the oldest committed event. Each read request returns one word: first a header carrying the tag and the data-word count, then the data words in the order they were written. When the last word has been returned, the slot is released. A skip command releases the oldest event without reading the rest of it. Capture and readout proceed independently, so later events can be acquired while earlier ones drain. Status outputs report empty, full, busy, whether any event is present, and whether the oldest event has at least one data word. A scan responder uses these outputs.

Top module: `event_ring_buffer`

## Requirements
- R1: After reset, empty is 1, and full, busy, eventPresent, curHasData and rdValid are all 0.
- R2: Each rdReq accepted while an event is present returns one word, with rdValid, on the next clock. The first word of an event is its header. The header has the data-word count in bits [4:0], the tag in bits [7:5], and zeros above. The data words follow, in write order.
- R3: Tags start at 0 after reset. Each committed event receives the next tag, modulo 8. A discarded event does not use up a tag.
- R4: At most eight committed events are held, and full is 1 whenever eight are held. A start strobe is refused while full is 1, and the data and end strobes that follow it are ignored. Once a slot is released, a new start is accepted.
- R5: Read requests are served while an event is being captured or is in its clear window.
- R6: skipEvent releases the oldest event, including partway through its readout, and the next read returns the following event's header. When skipEvent and rdReq occur in the same cycle, the skip is performed and no word is returned. skipEvent while empty has no effect.
- R7: A closed event becomes present only after clearWindow clock cycles following its end strobe. A rising edge of fastClear within those cycles discards the event, and the buffer stays empty if it was empty before.
- R8: fastClear acts only on a rising edge seen inside the window. A level held high from before the window, or an edge while idle or capturing, discards nothing.
- R9: busy is 1 from the cycle after an accepted start until the event is committed or discarded.
- R10: An event with no data words reads out as a header with count 0. While it is the oldest event, curHasData is 0. When the oldest event has data words, curHasData is 1.
- R11: At most 16 data words are kept per event. Further words are dropped, and the header count saturates at 16.
- R12: rdReq while no event is present produces no rdValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStart | input | 1 | Opens a new event |
| wrValid | input | 1 | Data word strobe while an event is open |
| wrData | input | 24 | Data word |
| wrEnd | input | 1 | Closes the open event and starts its clear window |
| fastClear | input | 1 | Discard request, leading-edge sensitive |
| clearWindow | input | 16 | Clear window length in clock cycles (0 acts as 1) |
| skipEvent | input | 1 | Release the oldest event unread |
| rdReq | input | 1 | Read the next word of the oldest event |
| rdData | output | 24 | Header or data word |
| rdValid | output | 1 | rdData holds a word this cycle |
| empty | output | 1 | No committed event held |
| full | output | 1 | Eight committed events held |
| busy | output | 1 | Capturing, in the clear window, or full |
| eventPresent | output | 1 | At least one committed event held |
| curHasData | output | 1 | The oldest event has at least one data word |

## Verification
The properties assume that skipEvent and rdReq are never X after reset. They also assume that the capture side opens an event only with wrStart and never sends wrValid outside an open event. The stimulus meets these assumptions: every input is driven to a known level from time zero, inputs change only on the falling clock edge, and every event is framed by a start and an end strobe. The refused-start case is the one exception, and it is deliberate, since the design must ignore its words. clearWindow is held constant at 4 throughout, so that the commit cycle after each end strobe can be predicted.

// File: rtl/evring_pkg.sv
package evring_pkg;
  localparam int EVENTS     = 8;
  localparam int SLOT_W     = $clog2(EVENTS);
  localparam int SLOT_WORDS = 16;
  localparam int IDX_W      = $clog2(SLOT_WORDS);
  localparam int CNT_W      = $clog2(SLOT_WORDS + 1);
  localparam int DATA_W     = 24;
  localparam int TAG_W      = 3;

  typedef struct packed {
    logic              wrEn;
    logic [SLOT_W-1:0] wrSlot;
    logic [IDX_W-1:0]  wrIdx;
    logic              metaEn;
    logic [CNT_W-1:0]  metaCount;
    logic [TAG_W-1:0]  metaTag;
    logic              rdEn;
    logic [SLOT_W-1:0] rdSlot;
    logic [CNT_W-1:0]  rdIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/evring_ctrl.sv
module evring_ctrl
  import evring_pkg::*;
#(
  parameter int WinW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStart,
  input  logic             wrValid,
  input  logic             wrEnd,
  input  logic             fastClear,
  input  logic [WinW-1:0]  clearWindow,
  input  logic             skipEvent,
  input  logic             rdReq,
  input  logic [CNT_W-1:0] curCount,
  output ctrlStrobe_t      strobe,
  output logic             full,
  output logic             empty,
  output logic             busy,
  output logic             curHasData
);
  localparam logic [SLOT_W:0]  EV_MAX   = EVENTS[SLOT_W:0];
  localparam logic [CNT_W-1:0] WORD_MAX = SLOT_WORDS[CNT_W-1:0];

  typedef enum logic [1:0] {ST_IDLE, ST_CAPTURE, ST_WINDOW} capState_t;

  capState_t         state;
  logic [SLOT_W-1:0] wrPtr, rdPtr;
  logic [SLOT_W:0]   evCount;
  logic [TAG_W-1:0]  tagCnt;
  logic [CNT_W-1:0]  wrCnt, rdIdx;
  logic [WinW-1:0]   winCnt;
  logic              fcPrev;

  logic fcEdge, startOk, wordOk, commitEv, discardEv, present, releaseEv, rdFire;

  assign present   = (evCount != '0);
  assign fcEdge    = fastClear & ~fcPrev;
  assign startOk   = (state == ST_IDLE) && wrStart && (evCount != EV_MAX);
  assign wordOk    = (state == ST_CAPTURE) && wrValid && (wrCnt != WORD_MAX);
  assign discardEv = (state == ST_WINDOW) && fcEdge;
  assign commitEv  = (state == ST_WINDOW) && !fcEdge && (winCnt <= WinW'(1));
  assign releaseEv = present && (skipEvent || (rdReq && rdIdx == curCount));
  assign rdFire    = present && rdReq && !skipEvent;

  always_comb begin
    strobe           = '0;
    strobe.wrEn      = wordOk;
    strobe.wrSlot    = wrPtr;
    strobe.wrIdx     = wrCnt[IDX_W-1:0];
    strobe.metaEn    = commitEv;
    strobe.metaCount = wrCnt;
    strobe.metaTag   = tagCnt;
    strobe.rdEn      = rdFire;
    strobe.rdSlot    = rdPtr;
    strobe.rdIdx     = rdIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      wrCnt  <= '0;
      winCnt <= '0;
      fcPrev <= 1'b0;
    end else begin
      fcPrev <= fastClear;
      unique case (state)
        ST_IDLE: if (startOk) begin
          state <= ST_CAPTURE;
          wrCnt <= '0;
        end
        ST_CAPTURE: begin
          if (wordOk) wrCnt <= wrCnt + 1'b1;
          if (wrEnd) begin
            state  <= ST_WINDOW;
            winCnt <= clearWindow;
          end
        end
        ST_WINDOW: begin
          if (discardEv || commitEv) state <= ST_IDLE;
          else winCnt <= winCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      evCount <= '0;
      tagCnt  <= '0;
      rdIdx   <= '0;
    end else begin
      if (commitEv) begin
        wrPtr  <= wrPtr + 1'b1;
        tagCnt <= tagCnt + 1'b1;
      end
      if (releaseEv) begin
        rdPtr <= rdPtr + 1'b1;
        rdIdx <= '0;
      end else if (rdFire) begin
        rdIdx <= rdIdx + 1'b1;
      end
      evCount <= evCount + {{SLOT_W{1'b0}}, commitEv} - {{SLOT_W{1'b0}}, releaseEv};
    end
  end

  assign full       = (evCount == EV_MAX);
  assign empty      = !present;
  assign busy       = (state != ST_IDLE) || full;
  assign curHasData = present && (curCount != '0);
endmodule

// File: rtl/evring_dp.sv
module evring_dp
  import evring_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  curCount,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int TOTAL = EVENTS * SLOT_WORDS;
  localparam int HDR_PAD = DATA_W - TAG_W - CNT_W;

  logic [DATA_W-1:0] mem [TOTAL];
  logic [CNT_W-1:0]  slotCount [EVENTS];
  logic [TAG_W-1:0]  slotTag [EVENTS];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[{strobe.wrSlot, strobe.wrIdx}] <= wrData;
  end

  for (genvar s = 0; s < EVENTS; s++) begin : g_meta
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotCount[s] <= '0;
        slotTag[s]   <= '0;
      end else if (strobe.metaEn && strobe.wrSlot == SLOT_W'(s)) begin
        slotCount[s] <= strobe.metaCount;
        slotTag[s]   <= strobe.metaTag;
      end
    end
  end

  assign curCount = slotCount[strobe.rdSlot];

  logic [IDX_W-1:0] dataIdx;
  assign dataIdx = IDX_W'(strobe.rdIdx - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) begin
        if (strobe.rdIdx == '0)
          rdData <= {{HDR_PAD{1'b0}}, slotTag[strobe.rdSlot], curCount};
        else
          rdData <= mem[{strobe.rdSlot, dataIdx}];
      end
    end
  end
endmodule

// File: rtl/event_ring_buffer.sv
module event_ring_buffer
  import evring_pkg::*;
#(
  parameter int WinW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStart,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEnd,
  input  logic              fastClear,
  input  logic [WinW-1:0]   clearWindow,
  input  logic              skipEvent,
  input  logic              rdReq,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              empty,
  output logic              full,
  output logic              busy,
  output logic              eventPresent,
  output logic              curHasData
);
  ctrlStrobe_t      strobe;
  logic [CNT_W-1:0] curCount;

  evring_ctrl #(.WinW(WinW)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .wrValid(wrValid), .wrEnd(wrEnd),
    .fastClear(fastClear), .clearWindow(clearWindow), .skipEvent(skipEvent),
    .rdReq(rdReq), .curCount(curCount), .strobe(strobe), .full(full),
    .empty(empty), .busy(busy), .curHasData(curHasData)
  );

  evring_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .curCount(curCount), .rdData(rdData), .rdValid(rdValid)
  );

  assign eventPresent = !empty;
endmodule

// File: rtl/evring_checker.sv
module evring_checker (
  input logic clk,
  input logic rstN,
  input logic rdReq,
  input logic skipEvent,
  input logic rdValid,
  input logic empty,
  input logic full,
  input logic busy,
  input logic eventPresent,
  input logic curHasData
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN) full |-> busy); // R4
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    full && !rdReq && !skipEvent |=> full); // R4
  AST_NOT_EMPTY_AND_FULL: assert property (@(posedge clk) disable iff (!rstN) !(empty && full)); // R4
  AST_READ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !eventPresent |=> !rdValid); // R12
  AST_SKIP_SUPPRESSES_READ: assert property (@(posedge clk) disable iff (!rstN)
    skipEvent |=> !rdValid); // R6
  AST_DATA_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    curHasData |-> eventPresent); // R10
  AST_COMMIT_VIA_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    empty && !busy |=> !eventPresent); // R7
endmodule

bind event_ring_buffer evring_checker chk_i (.*);

// File: tb/event_ring_buffer_tb_top.sv
module event_ring_buffer_tb_top;
  localparam int WIN = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStart = 0, wrValid = 0, wrEnd = 0, fastClear = 0, skipEvent = 0, rdReq = 0;
  logic [23:0] wrData = '0;
  logic [15:0] clearWindow = 16'(WIN);
  logic [23:0] rdData;
  logic        rdValid, empty, full, busy, eventPresent, curHasData;

  always #5 clk = ~clk;

  event_ring_buffer dut_i (.*);

  int nChecks = 0, nFails = 0;

  // reference model of committed events
  logic [23:0] mData [8][16];
  int          mCnt [8];
  int          mTagOf [8];
  int          mHead = 0, mNum = 0, tagCtr = 0;
  logic [23:0] expQ [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL R2/R12 unexpected word actual=%0h expected=none", rdData);
      end else begin
        logic [23:0] e;
        e = expQ.pop_front();
        if (rdData !== e) begin
          nFails++;
          $display("FAIL R2/R3 read word actual=%0h expected=%0h", rdData, e);
        end
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // open, fill and close one event; model updated when it should commit
  task automatic writeEvent(input int n, input int base, input bit clearIt, input bit expectAccept);
    int slot;
    @(negedge clk) wrStart = 1;
    @(negedge clk) wrStart = 0;
    for (int i = 0; i < n; i++) begin
      wrValid = 1; wrData = 24'(base + i);
      @(negedge clk);
    end
    wrValid = 0; wrEnd = 1;
    @(negedge clk) wrEnd = 0;
    if (clearIt) begin
      fastClear = 1; cyc(2); fastClear = 0;
    end
    cyc(WIN + 2);
    if (expectAccept && !clearIt) begin
      slot = (mHead + mNum) % 8;
      mCnt[slot] = (n > 16) ? 16 : n;
      for (int i = 0; i < 16; i++) mData[slot][i] = 24'(base + i);
      mTagOf[slot] = tagCtr % 8;
      tagCtr++;
      mNum++;
    end
  endtask

  function automatic logic [23:0] hdr(input int slot);
    return {16'b0, 3'(mTagOf[slot]), 5'(mCnt[slot])};
  endfunction

  task automatic readEvent();
    expQ.push_back(hdr(mHead));
    for (int i = 0; i < mCnt[mHead]; i++) expQ.push_back(mData[mHead][i]);
    rdReq = 1;
    cyc(mCnt[mHead] + 1);
    rdReq = 0;
    mHead = (mHead + 1) % 8; mNum--;
    cyc(1);
  endtask

  initial begin
    #500us;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1;
    cyc(1);
    // R1 reset state
    check(empty && !full && !busy && !eventPresent && !curHasData && !rdValid, "R1 reset flags",
          {empty, full, busy, eventPresent, curHasData, rdValid}, 6'b100000);

    // R12 read while empty; R6 skip while empty
    rdReq = 1; cyc(1); rdReq = 0;
    check(!rdValid, "R12 no word when empty", rdValid, 0);
    skipEvent = 1; cyc(1); skipEvent = 0; cyc(1);
    check(empty, "R6 skip on empty no effect", empty, 1);

    // R9 / R7 window timing
    @(negedge clk) wrStart = 1;
    @(negedge clk) wrStart = 0;
    check(busy, "R9 busy during capture", busy, 1);
    wrValid = 1; wrData = 24'h100;
    @(negedge clk) wrValid = 0; wrEnd = 1;
    @(negedge clk) wrEnd = 0;
    check(busy && !eventPresent, "R7 not present at window start", eventPresent, 0);
    cyc(3);
    check(!eventPresent, "R7 not present before window ends", eventPresent, 0);
    cyc(1);
    check(eventPresent && !busy, "R7 present after window", eventPresent, 1);
    mCnt[0] = 1; mData[0][0] = 24'h100; mTagOf[0] = 0; tagCtr = 1; mNum = 1;
    check(curHasData, "R10 curHasData with words", curHasData, 1);
    readEvent();  // R2 R3 tag 0
    check(empty, "R2 released after last word", empty, 1);

    // R7 fast clear discard, R3 tag not consumed
    writeEvent(2, 24'h200, 1'b1, 1'b1);
    check(empty, "R7 fast clear discards", eventPresent, 0);
    writeEvent(3, 24'h300, 1'b0, 1'b1);
    readEvent();  // expects tag 1

    // R8 held level and idle edge
    fastClear = 1; cyc(2); fastClear = 0; cyc(1); fastClear = 1;
    writeEvent(2, 24'h400, 1'b0, 1'b1);
    fastClear = 0;
    check(eventPresent, "R8 held level does not discard", eventPresent, 1);
    readEvent();

    // R10 zero-word event
    writeEvent(0, 24'h0, 1'b0, 1'b1);
    check(eventPresent && !curHasData, "R10 zero-word flag", curHasData, 0);
    readEvent();

    // R11 saturation
    writeEvent(18, 24'h500, 1'b0, 1'b1);
    readEvent();

    // R4 fill to eight, refuse ninth
    for (int e = 0; e < 8; e++) writeEvent(e % 3 + 1, 24'h1000 + e * 16, 1'b0, 1'b1);
    check(full && busy, "R4 full at eight", {full, busy}, 2'b11);
    writeEvent(2, 24'h9000, 1'b0, 1'b0);
    check(full && !busy == 1'b0, "R4 refused start keeps full", full, 1);
    readEvent();
    check(!full && !busy, "R4 slot freed", {full, busy}, 2'b00);
    writeEvent(1, 24'h2000, 1'b0, 1'b1);
    check(full, "R4 start accepted after release", full, 1);

    // R6 skip whole, skip mid-read, skip with read
    skipEvent = 1; cyc(1); skipEvent = 0;
    mHead = (mHead + 1) % 8; mNum--;
    expQ.push_back(hdr(mHead));
    rdReq = 1; cyc(1); rdReq = 0;
    skipEvent = 1; cyc(1); skipEvent = 0;
    mHead = (mHead + 1) % 8; mNum--;
    skipEvent = 1; rdReq = 1; cyc(1); skipEvent = 0; rdReq = 0;
    mHead = (mHead + 1) % 8; mNum--;
    cyc(1);
    check(mNum == 5, "R6 model count", mNum, 5);

    // R5 read while capturing
    @(negedge clk) wrStart = 1;
    @(negedge clk) wrStart = 0;
    readEvent();
    check(busy, "R5 capture still open", busy, 1);
    wrValid = 1; wrData = 24'h3000;
    @(negedge clk) wrValid = 0; wrEnd = 1;
    @(negedge clk) wrEnd = 0;
    readEvent();
    cyc(WIN + 2);
    begin
      int slot;
      slot = (mHead + mNum) % 8;
      mCnt[slot] = 1; mData[slot][0] = 24'h3000; mTagOf[slot] = tagCtr % 8;
      tagCtr++; mNum++;
    end
    while (mNum > 0) readEvent();
    check(empty, "R2 all drained", empty, 1);
    check(expQ.size() == 0, "R2 scoreboard drained", expQ.size(), 0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule